// File: doc/BRIEF.md
# Digital Frequency-Locked Oscillator Trimmer

This block trims an on-chip RC oscillator so that it stays locked to a slower reference clock. It is clocked by the oscillator itself. Between two successive reference ticks it counts oscillator cycles. At each tick it compares that count with a programmed compare value, which is the expected number of oscillator cycles per reference period. It then moves a calibration code up or down by one step. A larger code is assumed to make the oscillator faster. A programmable tolerance, normally half the cycles that one calibration step is worth, forms a dead band in which the code is left alone.

A small state machine controls the loop. It has four states:

- **ST_OFF**: the block is disabled, and software owns the calibration register.
- **ST_PRIME**: the block is waiting for the first reference tick. The partial period that ends at this tick is discarded.
- **ST_RUN**: every tick applies one trim decision.
- **ST_HALT**: a sleep that stops the oscillators is in force.

The state machine has five transitions:

- **T_ARM**: ST_OFF to ST_PRIME, taken when enabled and not sleeping.
- **T_LOCK**: ST_PRIME to ST_RUN, taken on a tick.
- **T_SLEEP**: ST_PRIME or ST_RUN to ST_HALT, taken when sleep is asserted.
- **T_WAKE**: ST_HALT to ST_PRIME, taken when sleep is released.
- **T_DISABLE**: any state to ST_OFF, taken when enable is low. This transition has priority over all others.

The calibration code is kept across sleep and across disable. The code loaded at reset is a parameter, which stands in for the stored factory trim.

Top module: `fll_trim`

## Requirements
- R1: After reset, cal_out equals the parameter CAL_RESET (default 32).
- R2: While enabled, cal_out changes only on the clock edge that ends a cycle with ref_tick high in state ST_RUN, and by at most one code per edge.
- R3: The measurement is the number of oscillator cycles from one ref_tick to the next, so ticks spaced P cycles apart measure P. If the measurement is greater than comp_val + tol, cal_out decreases by exactly one.
- R4: If the measurement is less than comp_val - tol, cal_out increases by exactly one. The lower bound is taken as 0 when tol exceeds comp_val.
- R5: A measurement in the inclusive range [comp_val - tol, comp_val + tol] leaves cal_out unchanged.
- R6: The first tick after enable, or after wake from sleep, causes no adjustment, whatever the length of the partial period it ends.
- R7: While sleep is high, ticks cause no adjustment. cal_out keeps its value and trimming resumes from that value after wake.
- R8: While enable is low, ticks cause no adjustment, and a cycle with sw_we high loads sw_data into cal_out on the next edge.
- R9: While enable is high, sw_we has no effect on cal_out.
- R10: cal_out saturates. A slow verdict at code 2^CAL_W-1 (63) and a fast verdict at code 0 leave the code unchanged.
- R11: In closed loop, the code converges from either side to the code whose period lies within the dead band, and then stays there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock being trimmed |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle reference tick, already synchronised to clk |
| enable | input | 1 | Enables automatic trimming |
| sleep | input | 1 | High while a sleep state that stops the oscillators is in force |
| comp_val | input | CNT_W | Expected oscillator cycles per reference period |
| tol | input | CNT_W | Dead-band half width in oscillator cycles |
| sw_we | input | 1 | Software write strobe for the calibration register |
| sw_data | input | CAL_W | Software write data |
| cal_out | output | CAL_W | Calibration code driven to the oscillator |

## Verification
The assertions assume the following about the inputs:

- ref_tick is a single-cycle pulse that is already synchronous to clk.
- Software writes are only meaningful while the block is disabled.
- Enable and sleep change on clean cycle boundaries.

The bench drives every input on the falling edge. It issues ticks as one-cycle pulses and changes enable and sleep only between ticks. A closed-loop oscillator model sets the tick spacing from the current calibration code, so that the measured count is exactly the number of cycles between ticks.

// File: rtl/fll_trim_pkg.sv
package fll_trim_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2,
        ST_HALT  = 2'd3
    } trim_state_e;

    typedef enum logic [1:0] {
        V_OK   = 2'd0,
        V_FAST = 2'd1,
        V_SLOW = 2'd2
    } verdict_e;

endpackage

// File: rtl/fll_trim_counter.sv
module fll_trim_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             ref_tick,
    output logic [CNT_W-1:0] meas
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Cleared at every tick; saturates rather than wrapping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!count_en || ref_tick) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The tick cycle itself completes the period.
    always_comb begin
        if (cnt_q == CNT_MAX) begin
            meas = CNT_MAX;
        end else begin
            meas = cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/fll_trim_cmp.sv
module fll_trim_cmp
    import fll_trim_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] meas,
    input  logic [CNT_W-1:0] comp_val,
    input  logic [CNT_W-1:0] tol,
    output verdict_e         verdict
);
    localparam int EW = CNT_W + 1;

    logic [EW-1:0] hi_bound;
    logic [EW-1:0] lo_bound;
    logic [EW-1:0] meas_x;

    always_comb begin
        meas_x   = {1'b0, meas};
        hi_bound = {1'b0, comp_val} + {1'b0, tol};
        if (comp_val > tol) begin
            lo_bound = {1'b0, comp_val - tol};
        end else begin
            lo_bound = '0;
        end
        if (meas_x > hi_bound) begin
            verdict = V_FAST;
        end else if (meas_x < lo_bound) begin
            verdict = V_SLOW;
        end else begin
            verdict = V_OK;
        end
    end
endmodule

// File: rtl/fll_trim_fsm.sv
module fll_trim_fsm
    import fll_trim_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        sleep,
    input  logic        ref_tick,
    output trim_state_e st_q,
    output logic        count_en,
    output logic        adj_en,
    output logic        sw_en
);
    trim_state_e st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: begin
                if (enable && !sleep) st_d = ST_PRIME;      // T_ARM
            end
            ST_PRIME: begin
                if (!enable)       st_d = ST_OFF;            // T_DISABLE
                else if (sleep)    st_d = ST_HALT;           // T_SLEEP
                else if (ref_tick) st_d = ST_RUN;            // T_LOCK
            end
            ST_RUN: begin
                if (!enable)       st_d = ST_OFF;            // T_DISABLE
                else if (sleep)    st_d = ST_HALT;           // T_SLEEP
            end
            ST_HALT: begin
                if (!enable)       st_d = ST_OFF;            // T_DISABLE
                else if (!sleep)   st_d = ST_PRIME;          // T_WAKE
            end
            default: st_d = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        count_en = 1'b0;
        adj_en   = 1'b0;
        sw_en    = 1'b0;
        unique case (st_q)
            ST_OFF:   sw_en = 1'b1;
            ST_PRIME: count_en = enable && !sleep;
            ST_RUN: begin
                count_en = enable && !sleep;
                adj_en   = ref_tick && enable && !sleep;
            end
            ST_HALT:  count_en = 1'b0;
            default:  sw_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/fll_trim_calreg.sv
module fll_trim_calreg
    import fll_trim_pkg::*;
#(
    parameter int CAL_W     = 6,
    parameter int CAL_RESET = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adj_en,
    input  verdict_e         verdict,
    input  logic             sw_en,
    input  logic             sw_we,
    input  logic [CAL_W-1:0] sw_data,
    output logic [CAL_W-1:0] cal_q
);
    localparam logic [CAL_W-1:0] CAL_MAX  = {CAL_W{1'b1}};
    localparam logic [CAL_W-1:0] CAL_INIT = CAL_W'(CAL_RESET);

    logic [CAL_W-1:0] cal_d;

    always_comb begin
        cal_d = cal_q;
        if (sw_en && sw_we) begin
            cal_d = sw_data;
        end else if (adj_en) begin
            unique case (verdict)
                V_FAST:  if (cal_q != '0)     cal_d = cal_q - 1'b1;
                V_SLOW:  if (cal_q != CAL_MAX) cal_d = cal_q + 1'b1;
                V_OK:    cal_d = cal_q;
                default: cal_d = cal_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q <= CAL_INIT;
        end else begin
            cal_q <= cal_d;
        end
    end
endmodule

// File: rtl/fll_trim.sv
module fll_trim
    import fll_trim_pkg::*;
#(
    parameter int CAL_W     = 6,
    parameter int CNT_W     = 10,
    parameter int CAL_RESET = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             enable,
    input  logic             sleep,
    input  logic [CNT_W-1:0] comp_val,
    input  logic [CNT_W-1:0] tol,
    input  logic             sw_we,
    input  logic [CAL_W-1:0] sw_data,
    output logic [CAL_W-1:0] cal_out
);
    trim_state_e      st_q;
    logic             count_en;
    logic             adj_en;
    logic             sw_en;
    logic [CNT_W-1:0] meas;
    verdict_e         verdict;

    fll_trim_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .sleep    (sleep),
        .ref_tick (ref_tick),
        .st_q     (st_q),
        .count_en (count_en),
        .adj_en   (adj_en),
        .sw_en    (sw_en)
    );

    fll_trim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .ref_tick (ref_tick),
        .meas     (meas)
    );

    fll_trim_cmp #(.CNT_W(CNT_W)) u_cmp (
        .meas     (meas),
        .comp_val (comp_val),
        .tol      (tol),
        .verdict  (verdict)
    );

    fll_trim_calreg #(.CAL_W(CAL_W), .CAL_RESET(CAL_RESET)) u_cal (
        .clk     (clk),
        .rst_n   (rst_n),
        .adj_en  (adj_en),
        .verdict (verdict),
        .sw_en   (sw_en),
        .sw_we   (sw_we),
        .sw_data (sw_data),
        .cal_q   (cal_out)
    );
endmodule

// File: rtl/fll_trim_chk.sv
module fll_trim_chk
    import fll_trim_pkg::*;
#(
    parameter int CAL_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             sw_we,
    input logic [CAL_W-1:0] sw_data,
    input logic [CAL_W-1:0] cal_out,
    input trim_state_e      st
);
    localparam logic [CAL_W-1:0] CAL_MAX = {CAL_W{1'b1}};
    localparam logic [CAL_W-1:0] ONE     = CAL_W'(1);

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st != ST_OFF) |->
            (cal_out == $past(cal_out)) ||
            (cal_out == $past(cal_out) + ONE) ||
            (cal_out == $past(cal_out) - ONE));

    a_r2_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st != ST_OFF) && !$past(ref_tick)) |-> $stable(cal_out));

    a_r6_prime_discard: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st == ST_PRIME) |-> $stable(cal_out));

    a_r7_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st == ST_HALT) |-> $stable(cal_out));

    a_r8_sw_load: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st == ST_OFF && sw_we) |-> (cal_out == $past(sw_data)));

    a_r10_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st == ST_RUN && cal_out == CAL_MAX) |-> (cal_out != '0));

    a_r10_no_wrap_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st == ST_RUN && cal_out == '0) |-> (cal_out != CAL_MAX));
endmodule

bind fll_trim fll_trim_chk #(.CAL_W(CAL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .sw_we    (sw_we),
    .sw_data  (sw_data),
    .cal_out  (cal_out),
    .st       (st_q)
);

// File: tb/sim_fll_trim.sv
`timescale 1ns/1ps
module sim_fll_trim;
    localparam int CAL_W = 6;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic             sleep = 1'b0;
    logic [CNT_W-1:0] comp_val = 10'd100;
    logic [CNT_W-1:0] tol = 10'd1;
    logic             sw_we = 1'b0;
    logic [CAL_W-1:0] sw_data = '0;
    logic [CAL_W-1:0] cal_out;
    logic             man_tick = 1'b0;
    logic             auto_tick = 1'b0;
    logic             auto_en = 1'b0;
    logic             ref_tick;
    int               acnt = 0;
    int               checks = 0;
    int               errors = 0;

    assign ref_tick = auto_en ? auto_tick : man_tick;

    always #2.5 clk = ~clk;

    fll_trim #(.CAL_W(CAL_W), .CNT_W(CNT_W), .CAL_RESET(32)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .enable(enable),
        .sleep(sleep), .comp_val(comp_val), .tol(tol), .sw_we(sw_we),
        .sw_data(sw_data), .cal_out(cal_out)
    );

    // Oscillator model: 40 + 2*code cycles per reference period.
    always @(negedge clk) begin
        if (!auto_en) begin
            acnt <= 0;
            auto_tick <= 1'b0;
        end else if (acnt >= 40 + 2 * int'(cal_out) - 1) begin
            acnt <= 0;
            auto_tick <= 1'b1;
        end else begin
            acnt <= acnt + 1;
            auto_tick <= 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick_after(input int p);
        repeat (p - 1) @(negedge clk);
        man_tick = 1'b1;
        @(negedge clk);
        man_tick = 1'b0;
    endtask

    task automatic sw_write(input int v);
        enable = 1'b0;
        @(negedge clk);
        sw_data = CAL_W'(v);
        sw_we = 1'b1;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic arm();
        enable = 1'b1;
        tick_after(5);
    endtask

    task automatic t_reset();
        check("R1 reset code", int'(cal_out), 32);
    endtask

    task automatic t_disabled();
        sw_write(40);
        check("R8 sw load", int'(cal_out), 40);
        tick_after(150);
        tick_after(150);
        check("R8 ticks ignored while disabled", int'(cal_out), 40);
    endtask

    task automatic t_fast_slow();
        arm();
        check("R6 first tick discarded", int'(cal_out), 40);
        tick_after(120);
        check("R3 fast dec", int'(cal_out), 39);
        tick_after(120);
        check("R3 fast dec again", int'(cal_out), 38);
        tick_after(80);
        check("R4 slow inc", int'(cal_out), 39);
    endtask

    task automatic t_band();
        tick_after(101);
        check("R5 upper edge of band", int'(cal_out), 39);
        tick_after(99);
        check("R5 lower edge of band", int'(cal_out), 39);
        tick_after(102);
        check("R3 just above band", int'(cal_out), 38);
        tick_after(98);
        check("R4 just below band", int'(cal_out), 39);
    endtask

    task automatic t_sw_ignored();
        @(negedge clk);
        sw_data = 6'd10;
        sw_we = 1'b1;
        @(negedge clk);
        sw_we = 1'b0;
        @(negedge clk);
        check("R9 sw write ignored when enabled", int'(cal_out), 39);
    endtask

    task automatic t_sleep();
        sleep = 1'b1;
        repeat (3) @(negedge clk);
        tick_after(120);
        tick_after(60);
        check("R7 ticks ignored in sleep", int'(cal_out), 39);
        sleep = 1'b0;
        tick_after(7);
        check("R6 first tick after wake discarded", int'(cal_out), 39);
        tick_after(120);
        check("R7 resumes from held code", int'(cal_out), 38);
    endtask

    task automatic t_saturate();
        sw_write(63);
        arm();
        tick_after(50);
        check("R10 top saturation", int'(cal_out), 63);
        sw_write(0);
        arm();
        tick_after(150);
        check("R10 bottom saturation", int'(cal_out), 0);
        tick_after(50);
        check("R4 leaves bottom", int'(cal_out), 1);
    endtask

    task automatic t_converge(input int start);
        int moved = 0;
        sw_write(start);
        enable = 1'b1;
        @(negedge clk);
        auto_en = 1'b1;
        repeat (7000) @(negedge clk);
        check("R11 converged code", int'(cal_out), 30);
        repeat (2000) begin
            @(negedge clk);
            if (cal_out != 6'd30) moved++;
        end
        check("R11 stable once locked", moved, 0);
        auto_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_fast_slow();
        t_band();
        t_sw_ignored();
        t_sleep();
        t_saturate();
        t_converge(5);
        t_converge(60);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule